// File: doc/BRIEF.md
# Selectable Registered or Bypassed Read Output Stage

This block is the last stage of the read path of a synchronous burst static memory. Every clock edge captures a command (hold, read, write or deselect) in an input register. During the cycle that follows a captured read, the storage array presents the read word. The block then drives a lane-split bidirectional data bus through two separate signal groups: a data word and an enable bit for each byte lane. The pad ring joins them into the tri-state bus.

A mode input chooses between two read paths while the block runs. In bypass mode the array word goes straight to the bus in the cycle after the read is captured. In registered mode the word is first caught by a rising-edge output register, so it reaches the bus one cycle later. Integrators with no mode control should tie the input high to get registered mode. Deselect and write commands switch the drivers off in the cycle right after their capture. This is one stage sooner than registered read data would reach the bus. As a result, a registered read that is followed at once by a deselect or a write becomes a dummy read that is never driven. A hold command starts no read and switches nothing off. An active-low output enable gates the drivers without any clock.

Top module: `rdout_stage`

## Requirements
- R1: While reset is held low and after it is released, before any read, every lane enable is 0 and the data output is all zeros.
- R2: With pipe_mode = 0, a read captured at edge k drives all lanes in the cycle after edge k, with dq_out equal to the arr_rdata present in that same cycle.
- R3: With pipe_mode = 1, a read captured at edge k drives all lanes in the cycle after edge k+1, with dq_out equal to the arr_rdata that was present in the cycle after edge k.
- R4: Reads on consecutive edges produce one new word per cycle on the bus in either mode, in capture order.
- R5: A deselect (cmd_in = 2'b11) captured at edge k turns every lane enable off in the cycle after edge k in both modes. This includes a registered-mode read captured at edge k-1.
- R6: A write (cmd_in = 2'b10) captured at edge k turns every lane enable off in the cycle after edge k, and a write never causes the bus to be driven later.
- R7: While oe_n is high all lane enables are 0, with no clock edge needed. When oe_n goes low, drivers turn on only if a read word is due in that cycle.
- R8: A hold (cmd_in = 2'b00) neither starts a read nor turns drivers off. In registered mode a read followed by a hold is driven in the hold cycle, and the bus is off in the next hold cycle. A read is cmd_in = 2'b01.
- R9: The lane enables are always all 0 or all 1. Every byte lane is driven on a read.
- R10: dq_out is all zeros in any cycle in which the lanes are not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| pipe_mode | input | 1 | 1 = registered read path, 0 = bypass read path |
| cmd_in | input | 2 | Command for this edge: 00 hold, 01 read, 10 write, 11 deselect |
| arr_rdata | input | DATA_W (32) | Array read word, valid in the cycle after a read is captured |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_out | output | DATA_W (32) | Data toward the bus pads |
| dq_oe | output | LANES (4) | Driver enable for each byte lane, active high |

## Verification
The bench targets latency: each single read is checked in exactly one cycle per mode. A design that swapped the two paths, or added or dropped a register, would show the word one cycle early or late. The bench also runs a registered read directly followed by a deselect or a write. A deselect pipelined as deep as a read would leak that dummy word onto the bus while a write is being set up. Hold cycles that follow reads, and garbage array words during non-read cycles, expose an output register that loads without a read or a kill that fires on hold. Finally, oe_n is toggled in the middle of a cycle to catch an enable that was registered instead of gated combinationally.

// File: rtl/rdout_pkg.sv
package rdout_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_DESEL = 2'b11
  } rd_cmd_e;
endpackage

// File: rtl/rdout_cmd_reg.sv
module rdout_cmd_reg
  import rdout_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  rd_cmd_e cmd_d,
  output rd_cmd_e cmd_q,
  output logic    s1_rd,
  output logic    s1_kill
);
  rd_cmd_e cmd_nxt;

  always_comb begin
    cmd_nxt = cmd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= CMD_DESEL;
    else        cmd_q <= cmd_nxt;
  end

  // a captured deselect or write switches drivers off at once (single-cycle deselect)
  always_comb begin
    s1_rd   = (cmd_q == CMD_READ);
    s1_kill = (cmd_q == CMD_DESEL) || (cmd_q == CMD_WRITE);
  end
endmodule

// File: rtl/rdout_pipe_reg.sv
module rdout_pipe_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_rd,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] pipe_data,
  output logic              pipe_vld
);
  logic [DATA_W-1:0] data_nxt;
  logic              load_en;

  always_comb begin
    load_en  = s1_rd;
    data_nxt = arr_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pipe_data <= '0;
    else if (load_en) pipe_data <= data_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_vld <= 1'b0;
    else        pipe_vld <= s1_rd;
  end
endmodule

// File: rtl/rdout_lane_drv.sv
module rdout_lane_drv #(
  parameter int LANE_W = 8
) (
  input  logic              pipe_mode,
  input  logic              drive_en,
  input  logic [LANE_W-1:0] flow_slice,
  input  logic [LANE_W-1:0] pipe_slice,
  output logic [LANE_W-1:0] lane_out,
  output logic              lane_oe
);
  logic [LANE_W-1:0] sel_slice;

  always_comb begin
    sel_slice = pipe_mode ? pipe_slice : flow_slice;
    lane_oe   = drive_en;
    lane_out  = drive_en ? sel_slice : '0;
  end
endmodule

// File: rtl/rdout_stage.sv
module rdout_stage
  import rdout_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic [1:0]        cmd_in,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic [LANES-1:0]  dq_oe
);
  localparam int LANE_W = DATA_W / LANES;

  rd_cmd_e           cmd_q;
  logic              s1_rd;
  logic              s1_kill;
  logic [DATA_W-1:0] pipe_data;
  logic              pipe_vld;
  logic              path_vld;
  logic              drive_en;

  rdout_cmd_reg u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_d   (rd_cmd_e'(cmd_in)),
    .cmd_q   (cmd_q),
    .s1_rd   (s1_rd),
    .s1_kill (s1_kill)
  );

  rdout_pipe_reg #(.DATA_W(DATA_W)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_rd     (s1_rd),
    .arr_rdata (arr_rdata),
    .pipe_data (pipe_data),
    .pipe_vld  (pipe_vld)
  );

  // three-term driver enable: path valid, no captured kill, async enable low
  always_comb begin
    path_vld = pipe_mode ? pipe_vld : s1_rd;
    drive_en = path_vld & ~s1_kill & ~oe_n;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rdout_lane_drv #(.LANE_W(LANE_W)) u_lane (
      .pipe_mode  (pipe_mode),
      .drive_en   (drive_en),
      .flow_slice (arr_rdata[g*LANE_W +: LANE_W]),
      .pipe_slice (pipe_data[g*LANE_W +: LANE_W]),
      .lane_out   (dq_out[g*LANE_W +: LANE_W]),
      .lane_oe    (dq_oe[g])
    );
  end

  assert_lanes_together_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == '0) || (dq_oe == '1));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == '0) |-> (dq_out == '0));

  assert_kill_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_DESEL) |-> (dq_oe == '0));

  assert_write_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_WRITE) |-> (dq_oe == '0));

  assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (dq_oe == '0));

  assert_flow_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && (cmd_q == CMD_READ) && !oe_n) |-> ((dq_oe == '1) && (dq_out == arr_rdata)));

  assert_pipe_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(cmd_q == CMD_READ) && (cmd_q != CMD_DESEL) && (cmd_q != CMD_WRITE) && !oe_n)
      |-> ((dq_oe == '1) && (dq_out == $past(arr_rdata))));
endmodule

// File: tb/test_rdout_stage.sv
module test_rdout_stage;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int LANES  = 4;
  localparam logic [1:0] C_HOLD = 2'b00, C_READ = 2'b01, C_WRITE = 2'b10, C_DESEL = 2'b11;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              pipe_mode;
  logic [1:0]        cmd_in;
  logic [DATA_W-1:0] arr_rdata;
  logic              oe_n;
  logic [DATA_W-1:0] dq_out;
  logic [LANES-1:0]  dq_oe;

  int checks = 0;
  int fails  = 0;
  logic [1:0]  cur_c, prev_c;
  logic [31:0] cur_w, prev_w, word_ctr;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdout_stage #(.DATA_W(DATA_W), .LANES(LANES)) i_rdout_stage (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .cmd_in(cmd_in),
    .arr_rdata(arr_rdata), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic check(input string req, input logic [LANES-1:0] exp_oe, input logic [DATA_W-1:0] exp_d);
    checks++;
    if (dq_oe !== exp_oe || dq_out !== exp_d) begin
      fails++;
      $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h", req, dq_oe, dq_out, exp_oe, exp_d);
    end
  endtask

  // expected bus in the current cycle, computed from the requirements
  task automatic expect_now(input string req);
    logic drv;
    logic [31:0] w;
    if (pipe_mode) begin
      drv = (prev_c == C_READ) && (cur_c != C_DESEL) && (cur_c != C_WRITE) && !oe_n;
      w   = prev_w;
    end else begin
      drv = (cur_c == C_READ) && !oe_n;
      w   = cur_w;
    end
    if (drv) check(req, '1, w);
    else     check({req, "/R10"}, '0, '0);
  endtask

  // one clock: command captured at next edge, array word set for the following cycle
  task automatic cyc(input logic [1:0] c, input logic oen, input string req);
    cmd_in = c;
    @(posedge clk);
    prev_c = cur_c; cur_c = c; prev_w = cur_w;
    @(negedge clk);
    word_ctr = word_ctr + 32'h0101_0103;
    cur_w = word_ctr;
    arr_rdata = cur_w;
    oe_n = oen;
    #1;
    expect_now(req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pipe_mode = 1'b1; cmd_in = C_READ; oe_n = 1'b0;
    arr_rdata = 32'hDEAD_BEEF; word_ctr = 32'h1000_0000;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R1 in reset", '0, '0);
    cmd_in = C_HOLD;
    rst_n = 1'b1;
    cur_c = C_DESEL; prev_c = C_DESEL; cur_w = '0; prev_w = '0;
    #1;
    check("R1 after release", '0, '0);
    cyc(C_HOLD, 1'b0, "R1 hold after reset");
  endtask

  task automatic t_flow_single;
    pipe_mode = 1'b0;
    cyc(C_DESEL, 1'b0, "R2 flush");
    cyc(C_READ,  1'b0, "R2 flow read");
    cyc(C_HOLD,  1'b0, "R2 flow after");
    cyc(C_HOLD,  1'b0, "R2 flow idle");
  endtask

  task automatic t_pipe_single;
    pipe_mode = 1'b1;
    cyc(C_DESEL, 1'b0, "R3 flush");
    cyc(C_READ,  1'b0, "R3 pipe access cycle");
    cyc(C_HOLD,  1'b0, "R3 pipe word R8");
    cyc(C_HOLD,  1'b0, "R8 pipe hold off");
    cyc(C_HOLD,  1'b0, "R8 pipe hold idle");
  endtask

  task automatic t_burst;
    for (int m = 0; m < 2; m++) begin
      pipe_mode = m[0];
      cyc(C_DESEL, 1'b0, "R4 flush");
      for (int i = 0; i < 4; i++) cyc(C_READ, 1'b0, "R4 burst");
      cyc(C_HOLD, 1'b0, "R4 burst tail");
      cyc(C_HOLD, 1'b0, "R4 burst end");
    end
  endtask

  task automatic t_scd;
    pipe_mode = 1'b1;
    cyc(C_DESEL, 1'b0, "R5 flush");
    cyc(C_READ,  1'b0, "R5 read");
    cyc(C_DESEL, 1'b0, "R5 dummy read killed");
    cyc(C_HOLD,  1'b0, "R5 after deselect");
    cyc(C_READ,  1'b0, "R5 read a");
    cyc(C_READ,  1'b0, "R5 read b");
    cyc(C_DESEL, 1'b0, "R5 burst killed");
    pipe_mode = 1'b0;
    cyc(C_READ,  1'b0, "R5 flow read");
    cyc(C_DESEL, 1'b0, "R5 flow deselect");
  endtask

  task automatic t_write;
    pipe_mode = 1'b1;
    cyc(C_DESEL, 1'b0, "R6 flush");
    cyc(C_READ,  1'b0, "R6 read");
    cyc(C_WRITE, 1'b0, "R6 write kills");
    cyc(C_HOLD,  1'b0, "R6 after write");
    cyc(C_WRITE, 1'b0, "R6 write");
    cyc(C_WRITE, 1'b0, "R6 write again");
    cyc(C_HOLD,  1'b0, "R6 write no drive");
    pipe_mode = 1'b0;
    cyc(C_READ,  1'b0, "R6 flow read");
    cyc(C_WRITE, 1'b0, "R6 flow write");
    cyc(C_HOLD,  1'b0, "R6 flow after write");
  endtask

  task automatic t_oe;
    pipe_mode = 1'b0;
    cyc(C_DESEL, 1'b0, "R7 flush");
    cyc(C_READ,  1'b1, "R7 read masked");
    oe_n = 1'b0; #1;
    check("R7 async enable", '1, cur_w);
    oe_n = 1'b1; #1;
    check("R7 async disable", '0, '0);
    cyc(C_HOLD,  1'b0, "R7 low without read");
    pipe_mode = 1'b1;
    cyc(C_READ,  1'b0, "R7 pipe access");
    cyc(C_HOLD,  1'b1, "R7 pipe masked");
    oe_n = 1'b0; #1;
    check("R7 pipe async enable", '1, prev_w);
    cyc(C_HOLD,  1'b0, "R7 pipe done");
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_flow_single();
    t_pipe_single();
    t_burst();
    t_scd();
    t_write();
    t_oe();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule